// File: doc/BRIEF.md
# SPI Host Data Word Packer

This block connects a 32-bit register bus to the byte-wide transmit and receive queues of an SPI host. A bus write to the transmit data port splits the word into four bytes and queues them, least-significant byte first. A bus read of the receive data port dequeues up to four bytes and assembles them into a word. The first queued byte goes into the lowest lane. Both 256-byte queues are held inside the block. The shift engine attaches on the other side through a pop strobe for transmit and a push strobe for receive.

A bus access handles one byte per clock. The bus sees a one-cycle completion strobe when the byte operations are done, or earlier if a queue runs out of room or out of data partway through the word. In that case the bytes already moved stay moved, the rest are lost, and a one-cycle overflow or underflow error pulse comes with the completion strobe. The block keeps a 32-bit status word that gives full and empty flags and word-granular depth counts for both queues. It discards the first transmit word written after reset. Each queue has its own flush input.

Top module: `spi_word_packer`

## Requirements
- R1: A transmit write queues bits 7:0 first, then 15:8, then 23:16, then 31:24, and the engine receives them in that order on `tx_byte_o`.
- R2: If the transmit queue is full when a byte lane comes up, that byte and all later lanes of the word are dropped. `err_overflow_o` pulses together with `bus_ready_o`, status bit 29 (transmit full) reads 1, and the bytes queued earlier in the word are kept.
- R3: The first transmit write after reset queues nothing and completes one cycle after it is accepted. Later writes are not affected.
- R4: A receive read puts the first dequeued byte in bits 7:0 and each later byte in the next higher lane.
- R5: If the receive queue is empty when a lane comes up, the read ends. `bus_rdata_o` holds the bytes collected so far, and the lanes not filled are zero. `err_underflow_o` pulses with `bus_ready_o`, and status bit 24 (receive empty) reads 1.
- R6: A receive read from a full queue clears status bit 25 (receive full). A byte pushed by the engine into a full receive queue is ignored.
- R7: Status bits 7:0 give the transmit depth in words, ceil(bytes/4). Bits 23:16 give the receive depth in words in the same way. All other unlisted status bits read 0.
- R8: Status bits 28 (transmit empty), 29 (transmit full), 24 (receive empty) and 25 (receive full) follow the queue occupancy every cycle. A successful transmit write clears bit 28.
- R9: A flush pulse empties its queue. After the flush, the queue's full bit reads 0 and its empty bit reads 1.
- R10: `bus_ready_o` is a single-cycle pulse. A word access that moves all four bytes shows it in the fifth cycle after the cycle in which `bus_valid_i` was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access request, held until `bus_ready_o` |
| bus_write_i | input | 1 | 1 = transmit data write, 0 = receive data read |
| bus_wdata_i | input | 32 | Word to transmit |
| bus_ready_o | output | 1 | One-cycle completion strobe |
| bus_rdata_o | output | 32 | Assembled receive word, valid with `bus_ready_o` |
| status_o | output | 32 | Depth fields and full/empty flags |
| err_overflow_o | output | 1 | Transmit overflow pulse |
| err_underflow_o | output | 1 | Receive underflow pulse |
| tx_pop_i | input | 1 | Engine takes the head transmit byte |
| tx_byte_o | output | 8 | Head transmit byte |
| rx_push_i | input | 1 | Engine delivers a receive byte |
| rx_byte_i | input | 8 | Received byte |
| tx_flush_i | input | 1 | Empty the transmit queue |
| rx_flush_i | input | 1 | Empty the receive queue |

## Verification
The hardest case to reach is a word that stops partway: the queue has to sit exactly one to three bytes short of full, or hold one to three bytes, at the moment the access starts. The stimulus gets there with directed steps. It fills the transmit queue with 64 words and then lets the engine take exactly two bytes before the next write. On the receive side it queues six bytes and reads twice. Random traffic then mixes writes, reads, engine strobes and occasional flushes against a queue model held in the bench. That model predicts the completion latency and the error pulses for each access.

// File: rtl/spi_pk_pkg.sv
package spi_pk_pkg;

  localparam int STAT_W   = 32;
  localparam int TXW_LSB  = 0;
  localparam int RXW_LSB  = 16;
  localparam int RXE_BIT  = 24;
  localparam int RXF_BIT  = 25;
  localparam int TXE_BIT  = 28;
  localparam int TXF_BIT  = 29;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } seq_state_e;

  // Number of words, whole or partial, that a byte count represents
  function automatic logic [7:0] words_held(input logic [15:0] nbytes);
    logic [15:0] sum;
    sum = nbytes + 16'd3;
    return sum[9:2];
  endfunction

  // Byte lane k of a word
  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] k);
    return w[{k, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/spi_pk_fifo.sv
module spi_pk_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end

endmodule

// File: rtl/spi_pk_seq.sv
module spi_pk_seq
  import spi_pk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [31:0] bus_wdata,
  output logic        bus_ready,
  output logic [31:0] bus_rdata,
  input  logic        tx_full,
  input  logic        rx_empty,
  input  logic [7:0]  rx_dout,
  output logic        tx_push,
  output logic [7:0]  tx_din,
  output logic        rx_pop,
  output logic        err_ovf,
  output logic        err_unf
);

  seq_state_e  state;
  logic        is_wr;
  logic [31:0] word;
  logic [1:0]  lane;
  logic        first_pend;
  logic        last_lane;

  assign last_lane = (lane == 2'd3);

  always_comb begin
    tx_push = (state == ST_MOVE) && is_wr && !tx_full;
    rx_pop  = (state == ST_MOVE) && !is_wr && !rx_empty;
    tx_din  = lane_of(word, lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      is_wr      <= 1'b0;
      word       <= '0;
      lane       <= '0;
      first_pend <= 1'b1;
      bus_ready  <= 1'b0;
      bus_rdata  <= '0;
      err_ovf    <= 1'b0;
      err_unf    <= 1'b0;
    end else begin
      bus_ready <= 1'b0;
      err_ovf   <= 1'b0;
      err_unf   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (bus_valid) begin
            if (bus_write && first_pend) begin
              first_pend <= 1'b0;
              bus_ready  <= 1'b1;
            end else begin
              state <= ST_MOVE;
              is_wr <= bus_write;
              word  <= bus_wdata;
              lane  <= '0;
              if (!bus_write) bus_rdata <= '0;
            end
          end
        end
        ST_MOVE: begin
          if (is_wr) begin
            if (tx_full) begin
              err_ovf   <= 1'b1;
              state     <= ST_IDLE;
              bus_ready <= 1'b1;
            end else if (last_lane) begin
              state     <= ST_IDLE;
              bus_ready <= 1'b1;
            end else begin
              lane <= lane + 1'b1;
            end
          end else begin
            if (rx_empty) begin
              err_unf   <= 1'b1;
              state     <= ST_IDLE;
              bus_ready <= 1'b1;
            end else begin
              bus_rdata[{lane, 3'b000} +: 8] <= rx_dout;
              if (last_lane) begin
                state     <= ST_IDLE;
                bus_ready <= 1'b1;
              end else begin
                lane <= lane + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
  import spi_pk_pkg::*;
#(
  parameter int FIFO_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [31:0] bus_wdata_i,
  output logic        bus_ready_o,
  output logic [31:0] bus_rdata_o,
  output logic [31:0] status_o,
  output logic        err_overflow_o,
  output logic        err_underflow_o,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_byte_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        tx_flush_i,
  input  logic        rx_flush_i
);

  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  // Named internal events, observed by the bound checker
  logic             tx_push, rx_pop;
  logic [7:0]       tx_din, rx_dout;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  spi_pk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid_i),
    .bus_write (bus_write_i),
    .bus_wdata (bus_wdata_i),
    .bus_ready (bus_ready_o),
    .bus_rdata (bus_rdata_o),
    .tx_full   (tx_full),
    .rx_empty  (rx_empty),
    .rx_dout   (rx_dout),
    .tx_push   (tx_push),
    .tx_din    (tx_din),
    .rx_pop    (rx_pop),
    .err_ovf   (err_overflow_o),
    .err_unf   (err_underflow_o)
  );

  spi_pk_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush_i),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (tx_pop_i),
    .dout  (tx_byte_o),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  spi_pk_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush_i),
    .push  (rx_push_i),
    .din   (rx_byte_i),
    .pop   (rx_pop),
    .dout  (rx_dout),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  always_comb begin
    status_o                  = '0;
    status_o[TXW_LSB +: 8]    = words_held(16'(tx_count));
    status_o[RXW_LSB +: 8]    = words_held(16'(rx_count));
    status_o[RXE_BIT]         = rx_empty;
    status_o[RXF_BIT]         = rx_full;
    status_o[TXE_BIT]         = tx_empty;
    status_o[TXF_BIT]         = tx_full;
  end

endmodule

// File: rtl/spi_word_packer_chk.sv
module spi_word_packer_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ready,
  input logic          err_ovf,
  input logic          err_unf,
  input logic          tx_push,
  input logic          rx_pop,
  input logic          tx_full,
  input logic          rx_empty,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full); // R2
  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> $past(tx_full)); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf || err_unf) |-> bus_ready); // R5
  AST_UNF_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unf |-> $past(rx_empty)); // R5
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready); // R10
  AST_TX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_count == '0)); // R9
  AST_RX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_count == '0)); // R9
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH)); // R8
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R6

endmodule

bind spi_word_packer spi_word_packer_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_ready(bus_ready_o),
  .err_ovf  (err_overflow_o),
  .err_unf  (err_underflow_o),
  .tx_push  (tx_push),
  .rx_pop   (rx_pop),
  .tx_full  (tx_full),
  .rx_empty (rx_empty),
  .tx_flush (tx_flush_i),
  .rx_flush (rx_flush_i),
  .tx_count (tx_count),
  .rx_count (rx_count)
);

// File: tb/tb_spi_word_packer.sv
`timescale 1ns/1ps
module tb_spi_word_packer;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_ready_o;
  logic [31:0] bus_rdata_o, status_o;
  logic        err_overflow_o, err_underflow_o;
  logic        tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic [7:0]  tx_byte_o, rx_byte_i = '0;
  logic        tx_flush_i = 1'b0, rx_flush_i = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  bit first_wr = 1'b1;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #10 clk = ~clk;

  spi_word_packer #(.FIFO_DEPTH(DEPTH)) dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] words_of(int n);
    return 8'((n + 3) / 4);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[7:0]   = words_of(txq.size());
    s[23:16] = words_of(rxq.size());
    s[24] = (rxq.size() == 0);
    s[25] = (rxq.size() == DEPTH);
    s[28] = (txq.size() == 0);
    s[29] = (txq.size() == DEPTH);
    return s;
  endfunction

  task automatic chk_status(string tag);
    chk(tag, "status", status_o, exp_status());
  endtask

  task automatic access(input bit wr, input logic [31:0] w, output logic [31:0] rd,
                        output bit ovf, output bit unf, output int lat);
    bus_valid_i = 1'b1;
    bus_write_i = wr;
    bus_wdata_i = w;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready_o);
    rd  = bus_rdata_o;
    ovf = err_overflow_o;
    unf = err_underflow_o;
    bus_valid_i = 1'b0;
  endtask

  task automatic tx_write(input logic [31:0] w, input string tag);
    logic [31:0] rd;
    bit ovf, unf;
    int lat, room, k, exp_lat;
    bit exp_ovf;
    if (first_wr) begin
      exp_lat = 1; exp_ovf = 1'b0; first_wr = 1'b0;
    end else begin
      room = DEPTH - txq.size();
      k = (room < 4) ? room : 4;
      exp_ovf = (room < 4);
      exp_lat = exp_ovf ? k + 2 : 5;
      for (int i = 0; i < k; i++) txq.push_back(w[i*8 +: 8]);
    end
    access(1'b1, w, rd, ovf, unf, lat);
    chk(tag, "write latency", 32'(lat), 32'(exp_lat));
    chk(tag, "overflow pulse", {31'b0, ovf}, {31'b0, exp_ovf});
    chk_status(tag);
  endtask

  task automatic rx_read(input string tag);
    logic [31:0] rd, exp_w;
    bit ovf, unf, exp_unf;
    int lat, k;
    exp_w = '0;
    k = (rxq.size() < 4) ? rxq.size() : 4;
    for (int i = 0; i < k; i++) exp_w[i*8 +: 8] = rxq.pop_front();
    exp_unf = (k < 4);
    access(1'b0, 32'h0, rd, ovf, unf, lat);
    chk(tag, "read word", rd, exp_w);
    chk(tag, "underflow pulse", {31'b0, unf}, {31'b0, exp_unf});
    chk(tag, "read latency", 32'(lat), exp_unf ? 32'(k + 2) : 32'd5);
    chk_status(tag);
  endtask

  task automatic eng_pop(input string tag);
    if (txq.size() == 0) return;
    chk(tag, "tx byte order", {24'b0, tx_byte_o}, {24'b0, txq.pop_front()});
    tx_pop_i = 1'b1;
    @(negedge clk);
    tx_pop_i = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    rx_push_i = 1'b1;
    rx_byte_i = b;
    if (rxq.size() < DEPTH) rxq.push_back(b);
    @(negedge clk);
    rx_push_i = 1'b0;
  endtask

  task automatic flush(input bit tx_side);
    if (tx_side) begin tx_flush_i = 1'b1; txq.delete(); end
    else begin rx_flush_i = 1'b1; rxq.delete(); end
    @(negedge clk);
    tx_flush_i = 1'b0;
    rx_flush_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R8", "reset status", status_o, 32'h1100_0000);
    chk("R10", "reset ready", {31'b0, bus_ready_o}, 32'h0);

    // R3: first write discarded
    tx_write(32'hA5A5_A5A5, "R3");
    // R1: byte order; R7/R8 status after writes
    tx_write(32'h4433_2211, "R1");
    for (int i = 0; i < 4; i++) eng_pop("R1");
    chk_status("R8");
    tx_write(32'h0807_0605, "R7");
    tx_write(32'h0C0B_0A09, "R7");
    eng_pop("R7");
    chk_status("R7");
    for (int i = 0; i < 4; i++) eng_pop("R7");
    chk_status("R7");
    flush(1'b1);
    chk_status("R9");

    // R2: fill, then overflow at lane 0 and at lane 2
    for (int i = 0; i < DEPTH / 4; i++) tx_write($urandom, "R2");
    chk("R2", "tx full bit", {31'b0, status_o[29]}, 32'h1);
    tx_write(32'hDEAD_BEEF, "R2");
    eng_pop("R2");
    eng_pop("R2");
    tx_write(32'h7766_5544, "R2");
    chk("R2", "tx full after partial", {31'b0, status_o[29]}, 32'h1);
    while (txq.size() != 0) eng_pop("R2");
    chk_status("R2");
    flush(1'b1);

    // R4/R5: full read, partial read, empty read
    for (int i = 0; i < 6; i++) eng_push(8'(8'h30 + i));
    chk_status("R7");
    rx_read("R4");
    rx_read("R5");
    rx_read("R5");

    // R6: full receive queue, ignored push, read clears full
    for (int i = 0; i < DEPTH; i++) eng_push(8'($urandom));
    chk("R6", "rx full bit", {31'b0, status_o[25]}, 32'h1);
    eng_push(8'hEE);
    chk_status("R6");
    rx_read("R6");
    chk("R6", "rx full cleared", {31'b0, status_o[25]}, 32'h0);
    flush(1'b0);
    chk_status("R9");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 40);
      if (op < 10)       tx_write($urandom, "R1");
      else if (op < 20)  eng_pop("R1");
      else if (op < 29)  eng_push(8'($urandom));
      else if (op < 38)  rx_read("R4");
      else if (op == 38) flush(1'b1);
      else               flush(1'b0);
    end
    chk_status("R8");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule